// File: doc/BRIEF.md
# Indexed RTC Register and Interrupt-Flag Controller

This block is the host-facing register side of a real-time clock. The host reaches a 128-byte register space through two byte addresses. A write to the even address selects a byte. Accesses to the odd address then read or write that byte. Four bytes of the space are control registers: a divider/rate register, a mode/enable register, a flag register and a status register. All other bytes are plain storage. Time counting and alarm matching live elsewhere. They reach this block as single-cycle event pulses for update-ended, alarm and periodic ticks.

The block merges those events into the flag register and combines flags with their enables into one interrupt request bit. It clears the flags when the host reads them. It also derives the update-in-progress status from a free-running phase counter that advances on a 32768 Hz strobe. A power-up reset loads the documented defaults. A separate synchronous system reset only clears interrupt enables and pending flags.

Top module: `rtc_regfile_ctl`

## Requirements
- R1: A write with `addr0`=0 loads `wdata[6:0]` as the index, and bit 7 is ignored. Writes and reads with `addr0`=1 access the indexed byte. A read with `addr0`=0 returns 0xFF. Bytes other than indices 0x0A..0x0D hold whatever was last written to them.
- R2: After power-up reset, index 0x0A reads 0x26, 0x0B reads 0x02, 0x0C reads 0x00 and 0x0D reads 0x80, and `irq` is low.
- R3: Writes to index 0x0C (flags) and 0x0D (status) are ignored. Index 0x0D always reads 0x80.
- R4: Bit 7 of index 0x0A is the read-only update-in-progress bit (UIP). A write to 0x0A stores only bits 6:0.
- R5: Each event pulse sets its flag in 0x0C: update sets bit 4, alarm sets bit 5 and periodic sets bit 6. The flag is set whatever the enables are. If a flag that was clear becomes set while its enable in 0x0B is 1, then IRQF (0x0C bit 7) is set and `irq` goes high on the next cycle. The enables are bit 4 for update, bit 5 for alarm and bit 6 for periodic.
- R6: A read of 0x0C returns the register's current value. On the same clock edge the register is cleared to 0x00 and `irq` drops.
- R7: If an event pulse arrives in the same cycle as a read of 0x0C, its flag (and IRQF, if enabled) survives the clear.
- R8: A write to 0x0B sets IRQF and raises `irq` when (new value & 0x0C & 0x70) is nonzero. Otherwise it clears IRQF and lowers `irq`. The flag bits themselves are kept.
- R9: UIP reads 1 when three conditions hold. The phase counter must be in the last 8 of its 32768 strobe counts. The divider select (0x0A bits 6:4) must be 0, 1 or 2. The SET bit (0x0B bit 7) must be 0.
- R10: Setting SET, or putting the divider into reset (0x0A bits 6:5 = 11), forces UIP to 0. The divider reset also holds the phase at 0. Writing a running divider select while leaving divider reset with SET clear starts the phase at half a second (16384).
- R11: A `sys_reset` pulse clears bits 6, 5 and 3 of 0x0B and every flag of 0x0C, and lowers `irq`. Other bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, loads defaults |
| sys_reset | input | 1 | Synchronous system reset, clears enables and flags |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (triggers read side effects) |
| addr0 | input | 1 | Address bit 0: 0 index, 1 data |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the current address and index |
| evt_update | input | 1 | Update-ended event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_periodic | input | 1 | Periodic event pulse |
| tick_32k | input | 1 | 32768 Hz strobe advancing the phase counter |
| irq | output | 1 | Active-high interrupt request (IRQF) |

## Verification
A wrong flag or IRQF value shows up at `irq` one cycle after the event, write or reset that caused it. It also shows up in the value the host reads back from 0x0C on the next access. A phase counter that drifts or resets wrongly only shows when UIP is read, so the phase is checked at both edges of the 8-count window. It is also checked across wrap-around and after the half-second restart. A stale index or a storage fault shows on the first read-back of the affected byte.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam int IDX_W = 7;
  localparam logic [IDX_W-1:0] IDX_CTRL_A = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_CTRL_B = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_FLAGS  = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_VALID  = 7'h0D;

  localparam logic [7:0] A_POR       = 8'h26;
  localparam logic [7:0] B_POR       = 8'h02;
  localparam logic [7:0] VALID_CONST = 8'h80;
  localparam logic [7:0] FLAG_MASK   = 8'h70;
  localparam logic [7:0] B_SOFT_CLR  = 8'h68;
  localparam logic [7:0] EVEN_READ   = 8'hFF;

  typedef struct packed {
    logic periodic;
    logic alarm;
    logic update;
  } evt_t;

  // divider select value that lets the phase advance
  function automatic logic div_running(input logic [2:0] sel);
    return sel <= 3'd2;
  endfunction

  function automatic logic div_in_reset(input logic [2:0] sel);
    return sel[2:1] == 2'b11;
  endfunction

  function automatic logic [7:0] evt_bits(input evt_t ev);
    return {1'b0, ev.periodic, ev.alarm, ev.update, 4'b0000};
  endfunction

  // flags that become set now and were clear before, gated by enables
  function automatic logic fresh_enabled(input logic [7:0] base,
                                         input logic [7:0] enables,
                                         input evt_t ev);
    return |(evt_bits(ev) & ~base & enables & FLAG_MASK);
  endfunction

  function automatic logic [7:0] merge_events(input logic [7:0] base,
                                              input logic [7:0] enables,
                                              input evt_t ev);
    logic [7:0] res;
    res = base | evt_bits(ev);
    if (fresh_enabled(base, enables, ev)) res[7] = 1'b1;
    return res;
  endfunction

  function automatic logic pending_enabled(input logic [7:0] enables,
                                           input logic [7:0] flags);
    return |(enables & flags & FLAG_MASK);
  endfunction
endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_regfile_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr0,
  input  logic [IDX_W-1:0] wdata_idx,
  output logic [IDX_W-1:0] idx,
  output logic             wr_a,
  output logic             wr_b,
  output logic             wr_mem,
  output logic             rd_c
);
  logic data_wr;
  logic is_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idx <= '0;
    else if (wr_en && !addr0) idx <= wdata_idx;
  end

  always_comb begin
    data_wr = wr_en && addr0;
    is_ctl  = (idx == IDX_CTRL_A) || (idx == IDX_CTRL_B) ||
              (idx == IDX_FLAGS)  || (idx == IDX_VALID);
    wr_a    = data_wr && (idx == IDX_CTRL_A);
    wr_b    = data_wr && (idx == IDX_CTRL_B);
    wr_mem  = data_wr && !is_ctl;
    rd_c    = rd_en && addr0 && (idx == IDX_FLAGS);
  end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_div_phase.sv
module rtc_div_phase
  import rtc_regfile_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8,
  localparam int TICK_W = $clog2(TICKS_PER_SEC)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] div_cur,
  input  logic       a_write,
  input  logic [2:0] div_new,
  input  logic       set_mode,
  output logic       uip
);
  localparam logic [TICK_W-1:0] LAST  = TICK_W'(TICKS_PER_SEC - 1);
  localparam logic [TICK_W-1:0] HALF  = TICK_W'(TICKS_PER_SEC / 2);
  localparam logic [TICK_W-1:0] WSTART = TICK_W'(TICKS_PER_SEC - UIP_TICKS);

  logic [TICK_W-1:0] phase;
  logic              release_half;

  assign release_half = a_write && div_in_reset(div_cur) &&
                        !div_in_reset(div_new) && div_running(div_new) &&
                        !set_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (release_half) begin
      phase <= HALF;
    end else if (div_in_reset(div_cur)) begin
      phase <= '0;
    end else if (div_running(div_cur) && tick) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign uip = div_running(div_cur) && !set_mode && (phase >= WSTART);
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_reset,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wdata,
  output logic [6:0] a_q,
  output logic [7:0] b_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= A_POR[6:0];
      b_q <= B_POR;
    end else begin
      if (wr_a) a_q <= wdata[6:0];
      if (sys_reset)  b_q <= (wr_b ? wdata : b_q) & ~B_SOFT_CLR;
      else if (wr_b)  b_q <= wdata;
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_reset,
  input  logic       rd_c,
  input  logic       wr_b,
  input  logic [7:0] wdata,
  input  logic [7:0] b_q,
  input  evt_t       ev,
  output logic [7:0] c_q,
  output logic       raise_evt
);
  logic [7:0] base;
  logic [7:0] enables;
  logic [7:0] c_next;

  always_comb begin
    base    = rd_c ? 8'h00 : c_q;
    enables = wr_b ? wdata : b_q;
    if (wr_b) base[7] = pending_enabled(wdata, c_q);
    raise_evt = fresh_enabled(base, enables, ev);
    c_next    = merge_events(base, enables, ev);
    if (sys_reset) c_next = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= 8'h00;
    else        c_q <= c_next;
  end
endmodule

// File: rtl/rtc_regfile_ctl.sv
module rtc_regfile_ctl
  import rtc_regfile_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8,
  parameter int SPACE_BYTES   = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_reset,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr0,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       evt_update,
  input  logic       evt_alarm,
  input  logic       evt_periodic,
  input  logic       tick_32k,
  output logic       irq
);
  logic [IDX_W-1:0] idx;
  logic             wr_a, wr_b, wr_mem, rd_c;
  logic [6:0]       a_q;
  logic [7:0]       b_q, c_q, mem_rdata;
  logic             uip, raise_evt;
  evt_t             ev;

  assign ev = '{periodic: evt_periodic, alarm: evt_alarm, update: evt_update};

  rtc_host_port u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr0(addr0),
    .wdata_idx(wdata[IDX_W-1:0]), .idx(idx), .wr_a(wr_a), .wr_b(wr_b),
    .wr_mem(wr_mem), .rd_c(rd_c)
  );

  rtc_byte_store #(.DEPTH(SPACE_BYTES), .WIDTH(8)) u_store (
    .clk(clk), .we(wr_mem), .waddr(idx), .wdata(wdata),
    .raddr(idx), .rdata(mem_rdata)
  );

  rtc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .wr_a(wr_a),
    .wr_b(wr_b), .wdata(wdata), .a_q(a_q), .b_q(b_q)
  );

  rtc_div_phase #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .div_cur(a_q[6:4]),
    .a_write(wr_a), .div_new(wdata[6:4]), .set_mode(b_q[7]), .uip(uip)
  );

  rtc_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .rd_c(rd_c),
    .wr_b(wr_b), .wdata(wdata), .b_q(b_q), .ev(ev), .c_q(c_q),
    .raise_evt(raise_evt)
  );

  assign irq = c_q[7];

  always_comb begin
    if (!addr0) begin
      rdata = EVEN_READ;
    end else begin
      unique case (idx)
        IDX_CTRL_A: rdata = {uip, a_q};
        IDX_CTRL_B: rdata = b_q;
        IDX_FLAGS:  rdata = c_q;
        IDX_VALID:  rdata = VALID_CONST;
        default:    rdata = mem_rdata;
      endcase
    end
  end
endmodule

// File: rtl/rtc_regfile_checker.sv
module rtc_regfile_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_reset,
  input logic       wr_en,
  input logic       addr0,
  input logic [7:0] wdata,
  input logic [6:0] idx,
  input logic       evt_update,
  input logic       evt_alarm,
  input logic       evt_periodic,
  input logic       tick_32k,
  input logic       irq,
  input logic [7:0] b_q,
  input logic [7:0] c_q,
  input logic       uip,
  input logic       raise_evt,
  input logic       rd_c,
  input logic       wr_b
);
  logic any_evt;
  assign any_evt = evt_update || evt_alarm || evt_periodic;

  assert_event_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_evt && !sys_reset) |=> irq);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !any_evt && !sys_reset) |=> (!irq && c_q == 8'h00));

  assert_flag_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && evt_alarm && !sys_reset) |=> c_q[5]);

  assert_ro_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr0 && (idx == 7'h0C || idx == 7'h0D) && !any_evt && !sys_reset)
      |=> $stable(c_q));

  assert_enable_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && (|(wdata & c_q & 8'h70)) && !sys_reset) |=> irq);

  assert_enable_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && !(|(wdata & c_q & 8'h70)) && !any_evt && !sys_reset) |=> !irq);

  assert_uip_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(tick_32k || wr_en));

  assert_set_stops_uip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    b_q[7] |-> !uip);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> (!irq && c_q == 8'h00));
endmodule

bind rtc_regfile_ctl rtc_regfile_checker u_checker (
  .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .wr_en(wr_en),
  .addr0(addr0), .wdata(wdata), .idx(idx), .evt_update(evt_update),
  .evt_alarm(evt_alarm), .evt_periodic(evt_periodic), .tick_32k(tick_32k),
  .irq(irq), .b_q(b_q), .c_q(c_q), .uip(uip), .raise_evt(raise_evt),
  .rd_c(rd_c), .wr_b(wr_b)
);

// File: tb/rtc_regfile_ctl_bench.sv
`timescale 1ns/1ps
module rtc_regfile_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_reset = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr0 = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       evt_update = 1'b0, evt_alarm = 1'b0, evt_periodic = 1'b0;
  logic       tick_32k = 1'b0;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_regfile_ctl u_rtc_regfile_ctl (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .wr_en(wr_en),
    .rd_en(rd_en), .addr0(addr0), .wdata(wdata), .rdata(rdata),
    .evt_update(evt_update), .evt_alarm(evt_alarm),
    .evt_periodic(evt_periodic), .tick_32k(tick_32k), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] v);
    @(posedge clk); #1 wr_en = 1'b1; addr0 = 1'b0; wdata = v;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(posedge clk); #1 wr_en = 1'b1; addr0 = 1'b1; wdata = v;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    wr_idx(i); wr_data(v);
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(posedge clk); #1 rd_en = 1'b1; addr0 = 1'b1; #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i); rd_data(v);
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(posedge clk); #1 {evt_periodic, evt_alarm, evt_update} = ev;
    @(posedge clk); #1 {evt_periodic, evt_alarm, evt_update} = 3'b000;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1 tick_32k = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_32k = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ 8'h5C);
  endfunction

  initial begin
    #(5.0 * 190000);
    fails++;
    tests++;
    $display("FAIL watchdog expired before the sequence completed");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 power-up values
    check("R2 irq", {7'b0, irq}, 8'h00);
    rd_reg(8'h0A, v); check("R2 A", v, 8'h26);
    rd_reg(8'h0B, v); check("R2 B", v, 8'h02);
    rd_reg(8'h0C, v); check("R2 C", v, 8'h00);
    rd_reg(8'h0D, v); check("R2 D", v, 8'h80);

    // R1 storage sweep, index bit 7 ignored, even read 0xFF
    for (int i = 0; i < 128; i++) begin
      if (i >= 8'h0A && i <= 8'h0D) continue;
      wr_reg(8'(i) | ((i % 2) ? 8'h80 : 8'h00), pat(i));
    end
    for (int i = 0; i < 128; i++) begin
      if (i >= 8'h0A && i <= 8'h0D) continue;
      rd_reg(8'(i), v); check("R1 readback", v, pat(i));
    end
    @(posedge clk); #1 rd_en = 1'b1; addr0 = 1'b0; #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
    check("R1 even read", v, 8'hFF);

    // R3 read-only registers
    wr_reg(8'h0C, 8'hFF); check("R3 irq after C write", {7'b0, irq}, 8'h00);
    wr_reg(8'h0D, 8'h00);
    rd_reg(8'h0D, v); check("R3 D", v, 8'h80);
    rd_reg(8'h0C, v); check("R3 C", v, 8'h00);

    // R4 UIP bit not writable
    wr_reg(8'h0A, 8'hA5);
    rd_reg(8'h0A, v); check("R4 A", v, 8'h25);
    wr_reg(8'h0A, 8'h26);

    // R5 / R6 exhaustive enable x event sweep
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        logic exp_irq;
        exp_irq = |(3'(en) & 3'(ev));
        wr_reg(8'h0B, {1'b0, 3'(en), 4'b0010});
        pulse(3'(ev));
        check("R5 irq", {7'b0, irq}, {7'b0, exp_irq});
        rd_reg(8'h0C, v);
        check("R5 C value", v, {exp_irq, 3'(ev), 4'b0000});
        check("R6 irq after read", {7'b0, irq}, 8'h00);
        rd_data(v);
        check("R6 C cleared", v, 8'h00);
      end
    end

    // R7 event during read of C
    wr_reg(8'h0B, 8'h22);
    wr_idx(8'h0C);
    @(posedge clk); #1 rd_en = 1'b1; addr0 = 1'b1; evt_alarm = 1'b1; #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0; evt_alarm = 1'b0;
    check("R7 returned", v, 8'h00);
    check("R7 irq", {7'b0, irq}, 8'h01);
    rd_data(v); check("R7 flag kept", v, 8'hA0);

    // R8 enable write with pending flag
    wr_reg(8'h0B, 8'h02);
    pulse(3'b100);
    check("R8 no irq", {7'b0, irq}, 8'h00);
    wr_reg(8'h0B, 8'h42);
    check("R8 immediate irq", {7'b0, irq}, 8'h01);
    wr_reg(8'h0B, 8'h12);
    check("R8 lowered", {7'b0, irq}, 8'h00);
    rd_reg(8'h0C, v); check("R8 flag kept IRQF clear", v, 8'h40);
    wr_reg(8'h0B, 8'h02);

    // R9 UIP window
    ticks(32759);
    rd_reg(8'h0A, v); check("R9 before window", v, 8'h26);
    ticks(1);
    rd_data(v); check("R9 window start", v, 8'hA6);
    ticks(7);
    rd_data(v); check("R9 window end", v, 8'hA6);
    ticks(1);
    rd_data(v); check("R9 after wrap", v, 8'h26);
    ticks(32760);
    rd_data(v); check("R9 window again", v, 8'hA6);

    // R10 SET and divider reset
    wr_reg(8'h0B, 8'h82);
    rd_reg(8'h0A, v); check("R10 SET stops UIP", v, 8'h26);
    wr_reg(8'h0B, 8'h02);
    rd_reg(8'h0A, v); check("R10 SET released", v, 8'hA6);
    wr_reg(8'h0A, 8'h66);
    rd_data(v); check("R10 divider reset", v, 8'h66);
    wr_data(8'h26);
    ticks(16375);
    rd_data(v); check("R10 half second before", v, 8'h26);
    ticks(1);
    rd_data(v); check("R10 half second window", v, 8'hA6);
    ticks(8);

    // R11 system reset
    wr_reg(8'h0B, 8'h7A);
    pulse(3'b010);
    check("R11 irq set", {7'b0, irq}, 8'h01);
    @(posedge clk); #1 sys_reset = 1'b1;
    @(posedge clk); #1 sys_reset = 1'b0;
    check("R11 irq low", {7'b0, irq}, 8'h00);
    rd_reg(8'h0B, v); check("R11 B", v, 8'h12);
    rd_reg(8'h0C, v); check("R11 C", v, 8'h00);
    rd_reg(8'h20, v); check("R11 storage kept", v, pat(32));
    rd_reg(8'h0A, v); check("R11 A kept", v, 8'h26);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule